// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block stores the last resolved target address of conditional branches so that a fetch unit can redirect without waiting for the branch to execute. A lookup presents the fetch address of a branch. One clock later the block answers with a hit flag and, on a hit, the stored target. A hit also tells the downstream outcome predictor that its dynamic direction applies, because the two structures are coupled. On a miss the block supplies a static direction instead: a branch whose displacement is negative (its target lies behind it) is predicted taken, and a forward branch is predicted not taken.

A second port is driven when a branch resolves. Every resolved taken branch writes its target. If the branch already owns an entry, that entry is overwritten. Otherwise an entry is allocated in its set. Storage is 128 sets of 4 ways, 512 entries in all, and a tree pseudo-LRU chooses the way to replace. Branches whose addresses differ only above the index slice share a set. Once more of them are live than the set has ways, they evict one another.

Top module: `btb_assoc`

## Requirements
- R1: While reset is asserted, and in every cycle after it with no lookup, rsp_valid, rsp_hit and rsp_static_taken are 0. Reset invalidates every entry, so the first lookup of any address after reset misses.
- R2: The response to a lookup presented at a clock edge appears after that edge and holds for one cycle: rsp_valid equals lk_valid of the previous cycle.
- R3: A lookup hit returns the target of the most recent taken update for that branch. A later taken update replaces the stored target.
- R4: The set index is address bits [10:4] and the tag is bits [31:11]. Addresses that differ only in bits [3:0] hit the same entry. A difference in any tag bit or index bit gives a miss.
- R5: On a lookup miss, rsp_static_taken equals lk_back (1 = negative displacement). On a hit it is 0.
- R6: An update with up_taken = 0 changes no entry and no recency state.
- R7: Up to 4 branches that map to one set are held at the same time. A taken update for a fifth branch in that set evicts exactly one of them.
- R8: Allocation takes the lowest-numbered invalid way of the set. When no way is invalid, the victim comes from a 3-bit tree per set. Node 1 is the root, node 2 covers ways 0/1 and node 3 covers ways 2/3. A node bit of 0 points to its lower half, and the victim is found by following the bits from the root. Using a way sets every node on its path to point away from it.
- R9: Both a lookup hit and a taken update count as use of a way. When both fall in one set in the same cycle, the lookup's use is applied first and the update's use second.
- R10: A lookup in the same cycle as an update to the same entry sees the contents from before the update. The written data is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch address of the branch being looked up |
| lk_back | input | 1 | Sign of the branch displacement (1 = backward target) |
| up_valid | input | 1 | Resolved branch reported this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Resolved direction (1 = taken) |
| up_target | input | 32 | Resolved target address |
| rsp_valid | output | 1 | Response present for the lookup of the previous cycle |
| rsp_hit | output | 1 | Lookup hit; the dynamic direction applies |
| rsp_target | output | 32 | Predicted target, meaningful when rsp_hit is 1 |
| rsp_static_taken | output | 1 | Static direction on a miss |

## Verification
Every lookup result is due exactly one cycle after the request. An update changes what lookups see from the cycle after it is presented, and a lookup in the same cycle still sees the old entry. The bench drives each cycle's inputs at the falling edge and steps its reference model at the same moment. The model computes the response from its state before that cycle's update and then applies the update. The response is compared at the following falling edge, one rising edge later, so lookup and update timing are both checked at that one-cycle distance.

// File: rtl/btb_pkg.sv
package btb_pkg;
   // Elaboration helper shared by the buffer and its checker.
   function automatic bit is_pow2(int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/btb_way.sv
// One way of the buffer: valid bits, tags and targets for every set.
// Two read ports (lookup, update) and one write port.
module btb_way #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 7,
   parameter int unsigned TAG_W  = 21
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  a_set,
   input  logic [TAG_W-1:0]  a_tag,
   output logic              a_hit,
   output logic [ADDR_W-1:0] a_tgt,
   input  logic [IDX_W-1:0]  b_set,
   input  logic [TAG_W-1:0]  b_tag,
   output logic              b_hit,
   output logic              b_used,
   input  logic              we,
   input  logic [IDX_W-1:0]  w_set,
   input  logic [TAG_W-1:0]  w_tag,
   input  logic [ADDR_W-1:0] w_tgt
);
   localparam int unsigned SETS = 1 << IDX_W;

   logic [SETS-1:0]   used_q;
   logic [TAG_W-1:0]  tag_q [SETS];
   logic [ADDR_W-1:0] tgt_q [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  used_q        <= '0;
      else if (we) used_q[w_set] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (we) begin
         tag_q[w_set] <= w_tag;
         tgt_q[w_set] <= w_tgt;
      end
   end

   assign a_hit  = used_q[a_set] && (tag_q[a_set] == a_tag);
   assign a_tgt  = tgt_q[a_set];
   assign b_hit  = used_q[b_set] && (tag_q[b_set] == b_tag);
   assign b_used = used_q[b_set];
endmodule

// File: rtl/btb_plru.sv
// Tree pseudo-LRU state, one tree of WAYS-1 node bits per set.
// Node n has children 2n and 2n+1; leaves WAYS..2*WAYS-1 are the ways.
module btb_plru #(
   parameter int unsigned WAYS  = 4,
   parameter int unsigned IDX_W = 7
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lk_touch,
   input  logic [IDX_W-1:0]        lk_set,
   input  logic [$clog2(WAYS)-1:0] lk_way,
   input  logic                    up_touch,
   input  logic [IDX_W-1:0]        up_set,
   input  logic [$clog2(WAYS)-1:0] up_way,
   output logic [$clog2(WAYS)-1:0] victim
);
   localparam int unsigned SETS = 1 << IDX_W;
   localparam int unsigned LVL  = $clog2(WAYS);

   typedef logic [WAYS-1:1] tree_t;

   function automatic tree_t touch(tree_t t, logic [LVL-1:0] w);
      tree_t r = t;
      int    n = int'(w) + int'(WAYS);
      for (int l = 0; l < int'(LVL); l++) begin
         r[n / 2] = (n % 2 == 0);
         n = n / 2;
      end
      return r;
   endfunction

   function automatic logic [LVL-1:0] pick(tree_t t);
      int n = 1;
      for (int l = 0; l < int'(LVL); l++) n = 2 * n + int'(t[n]);
      return LVL'(n - int'(WAYS));
   endfunction

   tree_t tree_q [SETS];
   tree_t lk_new, up_base, up_new;

   always_comb begin
      lk_new  = touch(tree_q[lk_set], lk_way);
      up_base = (lk_touch && (lk_set == up_set)) ? lk_new : tree_q[up_set];
      up_new  = touch(up_base, up_way);
   end

   assign victim = pick(tree_q[up_set]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < int'(SETS); s++) tree_q[s] <= '0;
      end else begin
         if (lk_touch) tree_q[lk_set] <= lk_new;
         if (up_touch) tree_q[up_set] <= up_new;
      end
   end
endmodule

// File: rtl/btb_assoc.sv
// Set-associative branch target buffer with static direction fallback.
module btb_assoc
   import btb_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned SETS   = 128,
   parameter int unsigned WAYS   = 4,
   parameter int unsigned IDX_LO = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_pc,
   input  logic              lk_back,
   input  logic              up_valid,
   input  logic [ADDR_W-1:0] up_pc,
   input  logic              up_taken,
   input  logic [ADDR_W-1:0] up_target,
   output logic              rsp_valid,
   output logic              rsp_hit,
   output logic [ADDR_W-1:0] rsp_target,
   output logic              rsp_static_taken
);
   localparam int unsigned IDX_W  = $clog2(SETS);
   localparam int unsigned TAG_LO = IDX_LO + IDX_W;
   localparam int unsigned TAG_W  = ADDR_W - TAG_LO;
   localparam int unsigned WAY_W  = $clog2(WAYS);

   if (!is_pow2(WAYS) || WAYS < 2) begin : g_bad_ways
      $error("btb_assoc: WAYS must be a power of two >= 2");
   end
   if (!is_pow2(SETS) || SETS < 2) begin : g_bad_sets
      $error("btb_assoc: SETS must be a power of two >= 2");
   end
   if (TAG_LO >= ADDR_W) begin : g_bad_slice
      $error("btb_assoc: index slice leaves no tag bits");
   end
   if (IDX_LO > 0) begin : g_low_bits
      logic unused_low;
      assign unused_low = ^{lk_pc[IDX_LO-1:0], up_pc[IDX_LO-1:0]};
   end

   logic [IDX_W-1:0] lk_set, up_set;
   logic [TAG_W-1:0] lk_tag, up_tag;
   assign lk_set = lk_pc[IDX_LO +: IDX_W];
   assign up_set = up_pc[IDX_LO +: IDX_W];
   assign lk_tag = lk_pc[TAG_LO +: TAG_W];
   assign up_tag = up_pc[TAG_LO +: TAG_W];

   logic [WAYS-1:0]   lk_hit_w, up_hit_w, up_used_w, we_w;
   logic [ADDR_W-1:0] lk_tgt_w [WAYS];
   logic              wr_en;
   logic [WAY_W-1:0]  wr_way, plru_vic;

   for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
      assign we_w[w] = wr_en && (wr_way == WAY_W'(w));
      btb_way #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_way (
         .clk    (clk),          .rst_n (rst_n),
         .a_set  (lk_set),       .a_tag (lk_tag),
         .a_hit  (lk_hit_w[w]),  .a_tgt (lk_tgt_w[w]),
         .b_set  (up_set),       .b_tag (up_tag),
         .b_hit  (up_hit_w[w]),  .b_used(up_used_w[w]),
         .we     (we_w[w]),      .w_set (up_set),
         .w_tag  (up_tag),       .w_tgt (up_target)
      );
   end

   // Lookup side: hit way and selected target.
   logic              lk_any;
   logic [WAY_W-1:0]  lk_way;
   logic [ADDR_W-1:0] lk_tgt;
   always_comb begin
      lk_way = '0;
      lk_tgt = '0;
      for (int w = 0; w < int'(WAYS); w++) begin
         if (lk_hit_w[w]) begin
            lk_way = WAY_W'(w);
            lk_tgt = lk_tgt_w[w];
         end
      end
   end
   assign lk_any = lk_valid && (|lk_hit_w);

   // Update side: existing entry, else lowest free way, else tree victim.
   logic             up_any, has_free;
   logic [WAY_W-1:0] up_way, free_way;
   always_comb begin
      up_way   = '0;
      free_way = '0;
      has_free = 1'b0;
      for (int w = int'(WAYS) - 1; w >= 0; w--) begin
         if (up_hit_w[w]) up_way = WAY_W'(w);
         if (!up_used_w[w]) begin
            has_free = 1'b1;
            free_way = WAY_W'(w);
         end
      end
   end
   assign up_any = |up_hit_w;
   assign wr_en  = up_valid && up_taken;
   assign wr_way = up_any ? up_way : (has_free ? free_way : plru_vic);

   btb_plru #(.WAYS(WAYS), .IDX_W(IDX_W)) u_plru (
      .clk     (clk),     .rst_n   (rst_n),
      .lk_touch(lk_any),  .lk_set  (lk_set), .lk_way(lk_way),
      .up_touch(wr_en),   .up_set  (up_set), .up_way(wr_way),
      .victim  (plru_vic)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid        <= 1'b0;
         rsp_hit          <= 1'b0;
         rsp_target       <= '0;
         rsp_static_taken <= 1'b0;
      end else begin
         rsp_valid        <= lk_valid;
         rsp_hit          <= lk_any;
         rsp_target       <= lk_tgt;
         rsp_static_taken <= lk_valid && !(|lk_hit_w) && lk_back;
      end
   end
endmodule

// File: rtl/btb_assoc_chk.sv
// Property checker for btb_assoc, attached by bind below.
module btb_assoc_chk #(
   parameter int unsigned WAYS = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_valid,
   input logic            lk_back,
   input logic            rsp_valid,
   input logic            rsp_hit,
   input logic            rsp_static_taken,
   input logic [WAYS-1:0] lk_hit_w,
   input logic [WAYS-1:0] up_hit_w
);
   // R2: response appears one cycle after the request
   a_r2_rsp_timing: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (rsp_valid == $past(lk_valid)));

   // R1: no hit or static direction without a response
   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_static_taken));

   // R5: static direction never accompanies a hit
   a_r5_static_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_hit && rsp_static_taken));

   // R5: on a miss the static direction follows the displacement sign
   a_r5_static_sign: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && rsp_valid && !rsp_hit) |-> (rsp_static_taken == $past(lk_back)));

   // R7: a branch never lives in two ways of its set
   a_r7_one_way_lk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_hit_w));
   a_r7_one_way_up: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(up_hit_w));
endmodule

bind btb_assoc btb_assoc_chk #(.WAYS(WAYS)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .lk_valid        (lk_valid),
   .lk_back         (lk_back),
   .rsp_valid       (rsp_valid),
   .rsp_hit         (rsp_hit),
   .rsp_static_taken(rsp_static_taken),
   .lk_hit_w        (lk_hit_w),
   .up_hit_w        (up_hit_w)
);

// File: tb/btb_assoc_bench.sv
`timescale 1ns/1ps
module btb_assoc_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0, lk_back = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        up_valid = 1'b0, up_taken = 1'b0;
   logic [31:0] up_pc = '0, up_target = '0;
   logic        rsp_valid, rsp_hit, rsp_static_taken;
   logic [31:0] rsp_target;

   always #10 clk = ~clk;

   btb_assoc u_btb_assoc (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_back(lk_back),
      .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_target(rsp_target),
      .rsp_static_taken(rsp_static_taken)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Behavioural reference: 128 sets x 4 ways, 3-node tree per set.
   bit          mv [128][4];
   logic [20:0] mt [128][4];
   logic [31:0] mg [128][4];
   bit   [3:0]  mp [128];

   function automatic int sidx(logic [31:0] pc); return int'(pc[10:4]); endfunction

   function automatic bit [3:0] m_use(bit [3:0] t, int w);
      int n = w + 4;
      for (int l = 0; l < 2; l++) begin
         t[n / 2] = (n % 2 == 0);
         n = n / 2;
      end
      return t;
   endfunction

   function automatic int m_pick(bit [3:0] t);
      int n = 1;
      for (int l = 0; l < 2; l++) n = 2 * n + int'(t[n]);
      return n - 4;
   endfunction

   task automatic cyc(input bit lv, input logic [31:0] lpc, input bit lb,
                      input bit uv, input logic [31:0] upc, input bit ut,
                      input logic [31:0] utg, input string req);
      int li, ui, hw, uw;
      bit e_hit, e_st;
      logic [31:0] e_tgt;
      lk_valid = lv; lk_pc = lpc; lk_back = lb;
      up_valid = uv; up_pc = upc; up_taken = ut; up_target = utg;
      li = sidx(lpc); ui = sidx(upc); hw = -1; uw = -1;
      for (int w = 0; w < 4; w++) begin
         if (lv && mv[li][w] && mt[li][w] == lpc[31:11]) hw = w;
         if (mv[ui][w] && mt[ui][w] == upc[31:11]) uw = w;
      end
      e_hit = (hw >= 0);
      e_tgt = e_hit ? mg[li][hw] : 32'h0;
      e_st  = lv && !e_hit && lb;
      if (uv && ut && uw < 0) begin
         for (int w = 3; w >= 0; w--) if (!mv[ui][w]) uw = w;
         if (uw < 0) uw = m_pick(mp[ui]);
      end
      if (e_hit) mp[li] = m_use(mp[li], hw);
      if (uv && ut) begin
         mv[ui][uw] = 1'b1; mt[ui][uw] = upc[31:11]; mg[ui][uw] = utg;
         mp[ui] = m_use(mp[ui], uw);
      end
      @(posedge clk);
      @(negedge clk);
      check(rsp_valid == lv, req, "rsp_valid", 32'(rsp_valid), 32'(lv));
      check(rsp_hit == e_hit, req, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
      check(rsp_static_taken == e_st, req, "rsp_static_taken",
            32'(rsp_static_taken), 32'(e_st));
      if (e_hit) check(rsp_target == e_tgt, req, "rsp_target", rsp_target, e_tgt);
   endtask

   task automatic look(input logic [31:0] pc, input bit back, input string req);
      cyc(1'b1, pc, back, 1'b0, 32'h0, 1'b0, 32'h0, req);
   endtask

   task automatic upd(input logic [31:0] pc, input bit tk, input logic [31:0] tg,
                      input string req);
      cyc(1'b0, 32'h0, 1'b0, 1'b1, pc, tk, tg, req);
   endtask

   initial begin
      #(20.0 * 200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   localparam logic [31:0] PA = 32'h0000_1230;
   localparam logic [31:0] PS = 32'h0000_0450;

   initial begin
      for (int s = 0; s < 128; s++) begin
         mp[s] = '0;
         for (int w = 0; w < 4; w++) mv[s][w] = 1'b0;
      end
      // R1: outputs quiet under reset even with a lookup pending
      lk_valid = 1'b1; lk_pc = PA; lk_back = 1'b1;
      repeat (3) @(negedge clk);
      check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", 32'(rsp_valid), 0);
      check(rsp_hit == 1'b0, "R1", "rsp_hit in reset", 32'(rsp_hit), 0);
      check(rsp_static_taken == 1'b0, "R1", "static in reset", 32'(rsp_static_taken), 0);
      lk_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);

      look(PA, 1'b1, "R1 R5 backward miss");
      look(PA, 1'b0, "R1 R5 forward miss");
      cyc(1'b0, PA, 1'b1, 1'b0, 32'h0, 1'b0, 32'h0, "R1 R2 idle");
      upd(PA, 1'b1, 32'h0000_8000, "R3 write");
      look(PA, 1'b1, "R3 R5 hit");
      upd(PA, 1'b1, 32'h0000_9000, "R3 overwrite");
      look(PA, 1'b0, "R3 new target");
      look(PA | 32'h0000_000F, 1'b1, "R4 low bits ignored");
      look(PA ^ 32'h0000_0800, 1'b1, "R4 tag bit 11");
      look(PA ^ 32'h8000_0000, 1'b0, "R4 tag bit 31");
      look(PA ^ 32'h0000_0010, 1'b1, "R4 index bit 4");
      upd(32'h0000_2340, 1'b0, 32'h1, "R6 not-taken new");
      look(32'h0000_2340, 1'b1, "R6 no allocation");
      upd(PA, 1'b0, 32'h0000_7000, "R6 not-taken existing");
      look(PA, 1'b0, "R6 target kept");
      // R10: same-cycle lookup sees old data
      cyc(1'b1, PA, 1'b0, 1'b1, PA, 1'b1, 32'h0000_A000, "R10 same-cycle old");
      look(PA, 1'b0, "R10 new visible");
      cyc(1'b1, 32'h0000_3330, 1'b1, 1'b1, 32'h0000_3330, 1'b1, 32'h44, "R10 same-cycle miss");
      look(32'h0000_3330, 1'b1, "R10 allocated");

      // R7/R8: fill one set with ways 0..3 in order; victim then is way 0.
      // A hit on the first branch moves the victim to way 2 (third branch).
      for (int k = 0; k < 4; k++) upd(PS + (k << 11), 1'b1, 32'h100 + k, "R8 fill");
      for (int k = 0; k < 4; k++) look(PS + (k << 11), 1'b0, "R7 four held");
      look(PS, 1'b0, "R9 hit refreshes");
      upd(PS + (4 << 11), 1'b1, 32'h104, "R7 fifth allocates");
      look(PS + (2 << 11), 1'b1, "R8 third branch evicted");
      look(PS + (0 << 11), 1'b0, "R9 refreshed kept");
      look(PS + (1 << 11), 1'b0, "R7 second kept");
      look(PS + (3 << 11), 1'b0, "R7 fourth kept");
      look(PS + (4 << 11), 1'b0, "R7 fifth held");

      // R9 and general traffic on two crowded sets
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] a, b;
         a = {18'h0, 3'($urandom_range(0, 7)), 6'h08, 1'($urandom_range(0, 1)), 4'($urandom)};
         b = $urandom_range(0, 3) == 0 ? a :
             {18'h0, 3'($urandom_range(0, 7)), 6'h08, 1'($urandom_range(0, 1)), 4'($urandom)};
         cyc(1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), b, ($urandom_range(0, 9) < 7), $urandom,
             "R9 mixed traffic");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule